// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Lookup

This block decides in a single cycle whether a 32-bit fetch address is held in a direct-mapped cache and, when it is, returns the addressed longword. Every line holds 16 bytes, one tag and one valid bit. A lookup combines the registered tag, valid and data arrays with the request inputs, so `hit`, `miss` and `rdData` settle in the same cycle the request is presented. When the address is absent the block raises `miss`, so the surrounding logic can start an external fetch and then hand the whole line back through the refill port.

A mode input chooses between two arrangements of the 128-line array. In unified mode the whole array serves one kind of access. The line index is address bits [10:4] and the tag compare uses bits [31:11]. In split mode the array is cut in two halves: instruction accesses use the lower half and data accesses use the upper half. The index then narrows to bits [9:4] with the access type on top, and the compare widens to bits [31:10]. A refill always writes all four longwords, the tag and the valid bit together. A synchronous invalidate-all input clears every valid bit.

Top module: `cache_lookup_top`

## Requirements
- R1: While `rst_n` is low every valid bit is cleared, so after reset every lookup reports a miss and `rdData` is zero.
- R2: With `splitMode`=0, the line index is `reqAddr[10:4]` and a hit needs the stored tag bits that correspond to address [31:11] to equal `reqAddr[31:11]`. Address bit 10 takes no part in the compare.
- R3: With `splitMode`=1, the line index is {`reqIsData`, `reqAddr[9:4]`}, so data accesses use lines 64..127 and instruction accesses use lines 0..63. A hit needs the stored tag to equal `reqAddr[31:10]`.
- R4: `hit` is 1 in the same cycle as a valid request whose indexed line is valid and whose tag matches. No clock edge lies between request and answer.
- R5: On a hit, `rdData` is longword `reqAddr[3:2]` of the stored line. Longword n occupies `fillLine[32n+31:32n]`. Whenever `hit` is 0, `rdData` is zero.
- R6: `miss` equals `reqValid` and not `hit`. When `reqValid` is 0, both `hit` and `miss` are 0.
- R7: A refill (`fillValid`=1) writes the tag `fillAddr[31:10]`, all four longwords and a set valid bit at the clock edge. The line index is chosen from `fillAddr` by the rules of R2/R3, using the current `splitMode` and `fillIsData`. The new line replaces whatever that index held. It is first visible to a lookup in the following cycle.
- R8: `invAll`=1 clears every valid bit at the clock edge. A refill presented in the same cycle is discarded.
- R9: Two addresses that differ only in bit 10 hit or miss differently when the mode changes. A line filled in unified mode at address A (bit 10 = 0) hits in split mode for an instruction access to A. It misses for a data access to A and for an instruction access to A with bit 10 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all valid bits |
| splitMode | input | 1 | 0 = unified array, 1 = split into instruction and data halves |
| invAll | input | 1 | Synchronous clear of every valid bit |
| reqValid | input | 1 | A lookup request is present |
| reqIsData | input | 1 | Access type of the request: 1 = data, 0 = instruction |
| reqAddr | input | 32 | Fetch address of the request |
| hit | output | 1 | Request found in the array (same cycle) |
| miss | output | 1 | Request not found, an external fetch is needed |
| rdData | output | 32 | Addressed longword on a hit, zero otherwise |
| fillValid | input | 1 | Write a whole line this cycle |
| fillIsData | input | 1 | Access type of the refill (used in split mode) |
| fillAddr | input | 32 | Address of the line being refilled |
| fillLine | input | 128 | Four longwords of the line, longword 0 in the low bits |

## Verification
The bench builds the block with its package defaults: 32-bit addresses, four longwords per line and a 7-bit index, giving 128 lines. With this size both halves of the split array and the aliasing through address bit 10 can be reached with a handful of addresses. Directed sequences fill lines in one mode and look them up in the other. They replace a line in place, and they collide a refill with invalidate-all and with a lookup of the same line. A pseudo-random phase then mixes fills, lookups, mode changes and invalidates over a small pool of tags. A behavioural model holding per-line arrays is compared against the outputs every cycle.

// File: rtl/cache_lookup_pkg.sv
package cache_lookup_pkg;
  localparam int ADDR_W         = 32;
  localparam int WORD_W         = 32;
  localparam int WORDS_PER_LINE = 4;
  localparam int INDEX_W        = 7;

  localparam int WSEL_W      = $clog2(WORDS_PER_LINE);
  localparam int BYTE_SEL_W  = $clog2(WORD_W / 8);
  localparam int OFFSET_W    = WSEL_W + BYTE_SEL_W;
  localparam int LINE_W      = WORD_W * WORDS_PER_LINE;
  localparam int NUM_LINES   = 1 << INDEX_W;
  localparam int SPLIT_IDX_W = INDEX_W - 1;
  localparam int TAG_W       = ADDR_W - OFFSET_W - SPLIT_IDX_W;

  typedef struct packed {
    logic               clrAll;
    logic               fillEn;
    logic [INDEX_W-1:0] fillIdx;
    logic [TAG_W-1:0]   fillTag;
    logic               lookEn;
    logic [INDEX_W-1:0] lookIdx;
    logic [TAG_W-1:0]   lookTag;
    logic               tagLsbCare;
    logic [WSEL_W-1:0]  wordSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/cache_lookup_ctl.sv
module cache_lookup_ctl
  import cache_lookup_pkg::*;
(
  input  logic              splitMode,
  input  logic              invAll,
  input  logic              reqValid,
  input  logic              reqIsData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fillValid,
  input  logic              fillIsData,
  input  logic [ADDR_W-1:0] fillAddr,
  output ctrlStrobes_t      strb
);
  // Line index: unified uses the full index field, split puts the access
  // type on top of a one-bit-narrower field (R2, R3).
  function automatic logic [INDEX_W-1:0] lineIndex(
    input logic [ADDR_W-1:0] a,
    input logic              split,
    input logic              isData
  );
    if (split) return {isData, a[OFFSET_W +: SPLIT_IDX_W]};
    else       return a[OFFSET_W +: INDEX_W];
  endfunction

  function automatic logic [TAG_W-1:0] lineTag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  always_comb begin
    strb            = '0;
    strb.clrAll     = invAll;
    strb.fillEn     = fillValid && !invAll;          // R8: clear wins
    strb.fillIdx    = lineIndex(fillAddr, splitMode, fillIsData);
    strb.fillTag    = lineTag(fillAddr);
    strb.lookEn     = reqValid;
    strb.lookIdx    = lineIndex(reqAddr, splitMode, reqIsData);
    strb.lookTag    = lineTag(reqAddr);
    strb.tagLsbCare = splitMode;                     // R3 wide compare
    strb.wordSel    = reqAddr[BYTE_SEL_W +: WSEL_W];
  end

  logic unusedAddrBits;
  assign unusedAddrBits = ^{reqAddr[BYTE_SEL_W-1:0], fillAddr[OFFSET_W-1:0]};
endmodule

// File: rtl/cache_lookup_dp.sv
module cache_lookup_dp
  import cache_lookup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [LINE_W-1:0] fillLine,
  output logic              hit,
  output logic              miss,
  output logic [WORD_W-1:0] rdData
);
  logic [NUM_LINES-1:0] validQ;
  logic [TAG_W-1:0]     tagMem  [NUM_LINES];
  logic [LINE_W-1:0]    dataMem [NUM_LINES];

  // Valid bits: reset and invalidate-all clear, refill sets (R1, R7, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
    end else if (strb.clrAll) begin
      validQ <= '0;
    end else if (strb.fillEn) begin
      validQ[strb.fillIdx] <= 1'b1;
    end
  end

  // Tag and data arrays: whole-line writes only (R7)
  always_ff @(posedge clk) begin
    if (strb.fillEn) begin
      tagMem[strb.fillIdx]  <= strb.fillTag;
      dataMem[strb.fillIdx] <= fillLine;
    end
  end

  // Same-cycle lookup (R2, R3, R4)
  logic [TAG_W-1:0]  storedTag;
  logic [LINE_W-1:0] curLine;
  logic              tagUpperEq;
  logic              tagLsbEq;
  logic              lineValid;

  assign storedTag  = tagMem[strb.lookIdx];
  assign curLine    = dataMem[strb.lookIdx];
  assign lineValid  = validQ[strb.lookIdx];
  assign tagUpperEq = storedTag[TAG_W-1:1] == strb.lookTag[TAG_W-1:1];
  assign tagLsbEq   = !strb.tagLsbCare || (storedTag[0] == strb.lookTag[0]);

  assign hit  = strb.lookEn && lineValid && tagUpperEq && tagLsbEq;
  assign miss = strb.lookEn && !hit;

  // Longword select (R5)
  logic [WORD_W-1:0] lineWords [WORDS_PER_LINE];
  for (genvar w = 0; w < WORDS_PER_LINE; w++) begin : g_words
    assign lineWords[w] = curLine[w*WORD_W +: WORD_W];
  end

  assign rdData = hit ? lineWords[strb.wordSel] : '0;

  // ---------------- assertions ----------------
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.lookEn |-> (!hit && !miss));

  a_r6_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    strb.lookEn |-> (hit != miss));

  a_r5_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (rdData == '0));

  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> (validQ == '0));

  a_r7_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fillEn && !strb.clrAll) |=> validQ[$past(strb.fillIdx)]);

  a_r8_clear_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> !hit);
endmodule

// File: rtl/cache_lookup_top.sv
module cache_lookup_top
  import cache_lookup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              splitMode,
  input  logic              invAll,
  input  logic              reqValid,
  input  logic              reqIsData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              hit,
  output logic              miss,
  output logic [WORD_W-1:0] rdData,
  input  logic              fillValid,
  input  logic              fillIsData,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [LINE_W-1:0] fillLine
);
  ctrlStrobes_t strb;

  cache_lookup_ctl ctl_i (
    .splitMode  (splitMode),
    .invAll     (invAll),
    .reqValid   (reqValid),
    .reqIsData  (reqIsData),
    .reqAddr    (reqAddr),
    .fillValid  (fillValid),
    .fillIsData (fillIsData),
    .fillAddr   (fillAddr),
    .strb       (strb)
  );

  cache_lookup_dp dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .fillLine (fillLine),
    .hit      (hit),
    .miss     (miss),
    .rdData   (rdData)
  );
endmodule

// File: tb/cache_lookup_top_tb_top.sv
`timescale 1ns/1ps
module cache_lookup_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         splitMode = 1'b0;
  logic         invAll = 1'b1;
  logic         reqValid = 1'b0;
  logic         reqIsData = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic         hit, miss;
  logic [31:0]  rdData;
  logic         fillValid = 1'b0;
  logic         fillIsData = 1'b0;
  logic [31:0]  fillAddr = '0;
  logic [127:0] fillLine = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R4";

  always #2.5 clk = ~clk;   // 200 MHz

  cache_lookup_top dut_i (
    .clk(clk), .rst_n(rst_n), .splitMode(splitMode), .invAll(invAll),
    .reqValid(reqValid), .reqIsData(reqIsData), .reqAddr(reqAddr),
    .hit(hit), .miss(miss), .rdData(rdData),
    .fillValid(fillValid), .fillIsData(fillIsData), .fillAddr(fillAddr),
    .fillLine(fillLine)
  );

  // ---------- behavioural reference model ----------
  bit          mv [128];
  logic [21:0] mt [128];
  logic [127:0] md [128];

  function automatic int slotOf(input logic [31:0] a, input logic sp, input logic d);
    if (sp) return (d ? 64 : 0) + int'(a[9:4]);
    return int'(a[10:4]);
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a, input int w);
    return (a & 32'hFFFF_FFF0) ^ (32'h0101_0101 * (w + 1)) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [127:0] lineOf(input logic [31:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = pat(a, w);
    return l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mv[i] = 0;
    end else if (invAll) begin
      for (int i = 0; i < 128; i++) mv[i] = 0;
    end else if (fillValid) begin
      int s;
      s = slotOf(fillAddr, splitMode, fillIsData);
      mv[s] = 1; mt[s] = fillAddr[31:10]; md[s] = fillLine;
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic eh;
      logic [31:0] ed;
      int s;
      eh = 0; ed = 0;
      if (reqValid) begin
        s = slotOf(reqAddr, splitMode, reqIsData);
        eh = mv[s] && (splitMode ? (mt[s] == reqAddr[31:10])
                                 : (mt[s][21:1] == reqAddr[31:11]));
        if (eh) ed = md[s][int'(reqAddr[3:2])*32 +: 32];
      end
      chk(curReq, "model hit", {31'b0, hit}, {31'b0, eh});
      chk("R6", "model miss", {31'b0, miss}, {31'b0, reqValid && !eh});
      chk("R5", "model rdData", rdData, ed);
    end
  end

  // ---------- stimulus tasks ----------
  task automatic look(input logic [31:0] a, input logic d, input logic sp,
                      input string rq, input logic expHit, input logic [31:0] expData);
    @(posedge clk); #1;
    fillValid = 0; invAll = 0;
    reqValid = 1; reqAddr = a; reqIsData = d; splitMode = sp; curReq = rq;
    @(negedge clk);
    chk(rq, "hit", {31'b0, hit}, {31'b0, expHit});
    chk(rq, "miss", {31'b0, miss}, {31'b0, !expHit});
    chk(rq, "rdData", rdData, expData);
  endtask

  task automatic fill(input logic [31:0] a, input logic d, input logic sp);
    @(posedge clk); #1;
    reqValid = 0; invAll = 0;
    fillValid = 1; fillAddr = a; fillIsData = d; fillLine = lineOf(a); splitMode = sp;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    reqValid = 0; fillValid = 0; invAll = 0;
  endtask

  // ---------- watchdog ----------
  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------- directed and random sequence ----------
  localparam logic [31:0] A  = 32'h2000_0120;
  localparam logic [31:0] B  = A | 32'h400;
  localparam logic [31:0] A2 = 32'h5000_0120;
  localparam logic [31:0] C  = 32'h3000_0450;
  localparam logic [31:0] D  = 32'h4000_0460;
  localparam logic [31:0] E  = 32'h6000_0230;

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();

    // R1: reset state
    look(32'h1000_0000, 1, 0, "R1", 0, 0);
    look(A, 0, 0, "R1", 0, 0);
    look(C, 1, 1, "R1", 0, 0);

    // R2/R4/R5: unified fill, every longword in the line
    fill(A, 1, 0);
    for (int w = 0; w < 4; w++) look(A + 32'(w*4), 1, 0, "R5", 1, pat(A, w));
    look(A, 0, 0, "R4", 1, pat(A, 0));
    look(B, 1, 0, "R2", 0, 0);                      // other index
    look(A ^ 32'h800, 1, 0, "R2", 0, 0);            // same index, tag differs

    // R6: no request, no answer
    idle();
    @(negedge clk);
    chk("R6", "idle hit", {31'b0, hit}, 32'd0);
    chk("R6", "idle miss", {31'b0, miss}, 32'd0);

    // R9: mode flip on addresses differing in bit 10
    look(A, 0, 1, "R9", 1, pat(A, 0));
    look(A, 1, 1, "R9", 0, 0);
    look(B, 0, 1, "R9", 0, 0);
    look(A + 32'h8, 1, 0, "R9", 1, pat(A, 2));

    // R3: split data fill, upper half, wide compare
    fill(C, 1, 1);
    look(C + 32'hC, 1, 1, "R3", 1, pat(C, 3));
    look(C, 0, 1, "R3", 0, 0);
    look(C ^ 32'h400, 1, 1, "R3", 0, 0);
    // R2: unified compare ignores bit 10
    look(C, 0, 0, "R2", 1, pat(C, 0));
    look(C ^ 32'h400, 0, 0, "R2", 0, 0);
    fill(D, 0, 1);
    look(D ^ 32'h400, 1, 0, "R2", 1, pat(D, 0));

    // R7: replacement, and first visibility one cycle later
    fill(A2, 0, 0);
    look(A, 1, 0, "R7", 0, 0);
    look(A2 + 32'h4, 1, 0, "R7", 1, pat(A2, 1));
    @(posedge clk); #1;
    invAll = 0; fillValid = 1; fillAddr = E; fillIsData = 0; fillLine = lineOf(E);
    splitMode = 0; reqValid = 1; reqAddr = E; reqIsData = 0; curReq = "R7";
    @(negedge clk);
    chk("R7", "same-cycle fill hit", {31'b0, hit}, 32'd0);
    look(E, 0, 0, "R7", 1, pat(E, 0));

    // R8: invalidate-all wins over a same-cycle fill
    @(posedge clk); #1;
    reqValid = 0; invAll = 1; fillValid = 1; fillAddr = 32'h7000_0340;
    fillLine = lineOf(32'h7000_0340); splitMode = 0;
    look(32'h7000_0340, 0, 0, "R8", 0, 0);
    look(E, 0, 0, "R8", 0, 0);
    look(A2, 0, 0, "R8", 0, 0);

    // Random mix checked against the model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = {8'h10 + {6'b0, lfsr[9:8]}, 12'h000, 1'b0, lfsr[12:10], lfsr[7:2], 2'b00};
      @(posedge clk); #1;
      curReq = "R4";
      splitMode = (lfsr[20:16] == 5'd0) ? ~splitMode : splitMode;
      invAll = (lfsr[30:24] == 7'd3);
      fillValid = (lfsr[15:13] == 3'd0);
      fillAddr = ra; fillIsData = lfsr[23]; fillLine = lineOf(ra);
      reqValid = lfsr[22] | lfsr[21]; reqAddr = ra ^ {21'b0, lfsr[4], 10'b0};
      reqIsData = lfsr[23] ^ lfsr[5];
    end
    idle();
    idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule